// File: doc/BRIEF.md
# Dual-Strobe Up/Down Counter Stage

This block is a small synchronous counter with two separate strobe inputs, one that steps the value up and one that steps it down. Which way the count moves depends only on which strobe shows a rising level while the other strobe rests high. A parameter chooses between a decade stage, which counts 0 to 9, and a full binary stage, which counts 0 to 15. An active-low load copies a parallel data word into the counter. An active-high clear zeroes it and overrides every other input.

Each stage drives two active-low terminal outputs: an up-terminal pulse while the count sits at its top value and the up strobe is low, and a down-terminal pulse while the count sits at zero and the down strobe is low. Each pulse ends at the same clock edge where the count wraps. The next stage can therefore take them directly as its own up and down strobes, so several stages chain into a longer divider or counter. All control inputs are asynchronous levels. They pass through a two-flop synchroniser onto one system clock, and edges are found on the synchronised levels.

Top module: `updown_dual_strobe_counter`

## Requirements
- R1: Synchronous reset sets the count to 0 and both terminal outputs high. Leaving reset with both strobes high, load_n high and clear low causes no count.
- R2: While clear is high, the count becomes 0, whatever load_n, the data word and both strobes are doing.
- R3: While clear is low and load_n is low, the count takes the value of data_in. Strobe edges that arrive while load_n is low have no effect.
- R4: A rising edge on up_strobe while down_strobe is high adds one to the count. The top value (9 with DECADE=1, 15 with DECADE=0) wraps to 0.
- R5: A rising edge on down_strobe while up_strobe is high subtracts one from the count. A count of 0 wraps to the top value (9 with DECADE=1, 15 with DECADE=0).
- R6: No count occurs when both strobes rise in the same synchronised cycle. No count occurs when one strobe rises while the other is low.
- R7: carry_n is 0 exactly while the count equals the top value and the synchronised up strobe is low. It returns to 1 at the same clock edge where the count wraps to 0.
- R8: borrow_n is 0 exactly while the count is 0 and the synchronised down strobe is low. It returns to 1 at the same clock edge where the count wraps to the top value.
- R9: A strobe rising edge at the port shows on count after the third rising clock edge. It does not show after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| up_strobe | input | 1 | Asynchronous count-up strobe, idle high |
| down_strobe | input | 1 | Asynchronous count-down strobe, idle high |
| load_n | input | 1 | Asynchronous active-low parallel load |
| clear | input | 1 | Asynchronous active-high clear |
| data_in | input | WIDTH | Parallel load value |
| count | output | WIDTH | Registered counter value |
| carry_n | output | 1 | Active-low up-terminal pulse |
| borrow_n | output | 1 | Active-low down-terminal pulse |

## Verification
The assertions work on the synchronised levels. They assume every strobe, load or clear level stays put for at least two clock cycles, so the synchroniser gives one clean transition per change. They also assume data_in is stable whenever load_n is low. The stimulus holds each input pattern for four clock cycles. It changes inputs only at falling clock edges and sets data_in together with or before load_n, so every case falls inside these assumptions. Loaded values stay inside the decade range, because decoding of out-of-range decade states is not defined for this block.

// File: rtl/udc_pkg.sv
package udc_pkg;

  typedef enum logic [2:0] {
    ACT_HOLD  = 3'd0,
    ACT_CLEAR = 3'd1,
    ACT_LOAD  = 3'd2,
    ACT_INC   = 3'd3,
    ACT_DEC   = 3'd4
  } udc_act_e;

  // Index of each control level inside the synchroniser vector.
  localparam int unsigned SIG_UP    = 0;
  localparam int unsigned SIG_DN    = 1;
  localparam int unsigned SIG_LOADN = 2;
  localparam int unsigned SIG_CLR   = 3;
  localparam int unsigned NUM_CTRL  = 4;

endpackage

// File: rtl/udc_sync.sv
module udc_sync #(
  parameter int unsigned N = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);

  localparam int unsigned LAST = STAGES - 1;

  // One shift chain per control bit; reset loads the idle level so no edge appears.
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= {STAGES{IDLE[b]}};
      end else begin
        chain <= {chain[STAGES-2:0], async_i[b]};
      end
    end
    assign sync_o[b] = chain[LAST];
  end

endmodule

// File: rtl/udc_strobe_decode.sv
module udc_strobe_decode
  import udc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     up_lvl,
  input  logic     dn_lvl,
  input  logic     load_lvl_n,
  input  logic     clr_lvl,
  output logic     up_seen,
  output logic     dn_seen,
  output logic     up_rise,
  output logic     dn_rise,
  output udc_act_e act
);

  logic up_prev;
  logic dn_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_prev <= 1'b1;
      dn_prev <= 1'b1;
    end else begin
      up_prev <= up_lvl;
      dn_prev <= dn_lvl;
    end
  end

  assign up_rise = up_lvl & ~up_prev;
  assign dn_rise = dn_lvl & ~dn_prev;
  assign up_seen = up_prev;
  assign dn_seen = dn_prev;

  // Priority: clear, then load, then one clean strobe edge.
  always_comb begin
    act = ACT_HOLD;
    if (clr_lvl) begin
      act = ACT_CLEAR;
    end else if (!load_lvl_n) begin
      act = ACT_LOAD;
    end else if (up_rise && dn_lvl && !dn_rise) begin
      act = ACT_INC;
    end else if (dn_rise && up_lvl && !up_rise) begin
      act = ACT_DEC;
    end
  end

  // R1: leaving reset produces no strobe edge
  a_r1_no_false_edge: assert property (@(posedge clk)
    $fell(rst) |-> (!up_rise && !dn_rise) || up_lvl == 1'b1 && dn_lvl == 1'b1);

endmodule

// File: rtl/udc_count_core.sv
module udc_count_core
  import udc_pkg::*;
#(
  parameter int unsigned WIDTH = 4,
  parameter bit DECADE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  udc_act_e         act,
  input  logic [WIDTH-1:0] data_i,
  input  logic             up_lvl,
  input  logic             dn_lvl,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_n_o,
  output logic             borrow_n_o
);

  localparam logic [WIDTH-1:0] TOP = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;

  always_comb begin
    unique case (act)
      ACT_CLEAR: cnt_d = '0;
      ACT_LOAD:  cnt_d = data_i;
      ACT_INC:   cnt_d = (cnt_q == TOP) ? '0 : cnt_q + ONE;
      ACT_DEC:   cnt_d = (cnt_q == '0) ? TOP : cnt_q - ONE;
      default:   cnt_d = cnt_q;
    endcase
  end

  // Terminal outputs registered from next count and next delayed strobe level.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      carry_n_o  <= 1'b1;
      borrow_n_o <= 1'b1;
    end else begin
      cnt_q      <= cnt_d;
      carry_n_o  <= !((cnt_d == TOP) && !up_lvl);
      borrow_n_o <= !((cnt_d == '0) && !dn_lvl);
    end
  end

  assign count_o = cnt_q;

  // R2: clear zeroes the count
  a_r2_clear_zero: assert property (@(posedge clk) disable iff (rst)
    act == ACT_CLEAR |=> cnt_q == '0);

  // R3: load copies the data word
  a_r3_load_copy: assert property (@(posedge clk) disable iff (rst)
    act == ACT_LOAD |=> cnt_q == $past(data_i));

  // R4: increment with wrap at top
  a_r4_up_step: assert property (@(posedge clk) disable iff (rst)
    act == ACT_INC |=> cnt_q == (($past(cnt_q) == TOP) ? '0 : $past(cnt_q) + ONE));

  // R5: decrement with wrap at zero
  a_r5_down_step: assert property (@(posedge clk) disable iff (rst)
    act == ACT_DEC |=> cnt_q == (($past(cnt_q) == '0) ? TOP : $past(cnt_q) - ONE));

endmodule

// File: rtl/updown_dual_strobe_counter.sv
module updown_dual_strobe_counter
  import udc_pkg::*;
#(
  parameter int unsigned WIDTH = 4,
  parameter bit DECADE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_strobe,
  input  logic             down_strobe,
  input  logic             load_n,
  input  logic             clear,
  input  logic [WIDTH-1:0] data_in,
  output logic [WIDTH-1:0] count,
  output logic             carry_n,
  output logic             borrow_n
);

  localparam logic [WIDTH-1:0] TOP = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};
  localparam logic [NUM_CTRL-1:0] CTRL_IDLE = NUM_CTRL'(4'b0111);

  logic [NUM_CTRL-1:0] ctrl_async;
  logic [NUM_CTRL-1:0] ctrl_sync;
  logic     up_seen;
  logic     dn_seen;
  logic     up_rise;
  logic     dn_rise;
  udc_act_e act;

  always_comb begin
    ctrl_async            = '0;
    ctrl_async[SIG_UP]    = up_strobe;
    ctrl_async[SIG_DN]    = down_strobe;
    ctrl_async[SIG_LOADN] = load_n;
    ctrl_async[SIG_CLR]   = clear;
  end

  udc_sync #(
    .N      (NUM_CTRL),
    .STAGES (2),
    .IDLE   (CTRL_IDLE)
  ) i_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (ctrl_async),
    .sync_o  (ctrl_sync)
  );

  udc_strobe_decode i_decode (
    .clk        (clk),
    .rst        (rst),
    .up_lvl     (ctrl_sync[SIG_UP]),
    .dn_lvl     (ctrl_sync[SIG_DN]),
    .load_lvl_n (ctrl_sync[SIG_LOADN]),
    .clr_lvl    (ctrl_sync[SIG_CLR]),
    .up_seen    (up_seen),
    .dn_seen    (dn_seen),
    .up_rise    (up_rise),
    .dn_rise    (dn_rise),
    .act        (act)
  );

  udc_count_core #(
    .WIDTH  (WIDTH),
    .DECADE (DECADE)
  ) i_core (
    .clk        (clk),
    .rst        (rst),
    .act        (act),
    .data_i     (data_in),
    .up_lvl     (ctrl_sync[SIG_UP]),
    .dn_lvl     (ctrl_sync[SIG_DN]),
    .count_o    (count),
    .carry_n_o  (carry_n),
    .borrow_n_o (borrow_n)
  );

  // R6: simultaneous rising strobes leave the count alone
  a_r6_both_rise_hold: assert property (@(posedge clk) disable iff (rst)
    (up_rise && dn_rise && ctrl_sync[SIG_LOADN] && !ctrl_sync[SIG_CLR]) |=> $stable(count));

  // R6: a strobe rising while the other is low leaves the count alone
  a_r6_other_low_hold: assert property (@(posedge clk) disable iff (rst)
    ((up_rise && !ctrl_sync[SIG_DN]) || (dn_rise && !ctrl_sync[SIG_UP])) &&
    ctrl_sync[SIG_LOADN] && !ctrl_sync[SIG_CLR] |=> $stable(count));

  // R7: carry window tracks top value and delayed up level
  a_r7_carry_window: assert property (@(posedge clk) disable iff (rst)
    carry_n == !((count == TOP) && !up_seen));

  // R8: borrow window tracks zero and delayed down level
  a_r8_borrow_window: assert property (@(posedge clk) disable iff (rst)
    borrow_n == !((count == '0) && !dn_seen));

endmodule

// File: tb/test_updown_dual_strobe_counter.sv
module test_updown_dual_strobe_counter;

  localparam int unsigned W = 4;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned NVEC = 27;

  // Row: [23]clear [22]load_n [21]up [20]down [19:16]data [15:12]decade count
  // [11:8]binary count [7]carry dec [6]carry bin [5]borrow dec [4]borrow bin [3:0]req
  localparam logic [23:0] VEC [NVEC] = '{
    24'h7000F4, 24'h5000F4, 24'h7011F4, 24'h3888F3, 24'h7888F3,
    24'h5888F4, 24'h7899F4, 24'h589977, 24'h780AF4, 24'h680AD8,
    24'h7899F5, 24'h3000F3, 24'h7000F3, 24'h6000C8, 24'h709FF5,
    24'h509F37, 24'h7000F4, 24'h9500F2, 24'h1555F3, 24'h3555F3,
    24'h7555F3, 24'h4555F6, 24'h7555F6, 24'h6555F6, 24'h4555F6,
    24'h6555F6, 24'h7544F5
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up_strobe = 1'b1;
  logic down_strobe = 1'b1;
  logic load_n = 1'b1;
  logic clear = 1'b0;
  logic [W-1:0] data_in = '0;
  logic [W-1:0] cnt_dec, cnt_bin;
  logic cy_dec, cy_bin, bw_dec, bw_bin;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  updown_dual_strobe_counter #(.WIDTH(W), .DECADE(1'b1)) i_updown_dual_strobe_counter (
    .clk(clk), .rst(rst), .up_strobe(up_strobe), .down_strobe(down_strobe),
    .load_n(load_n), .clear(clear), .data_in(data_in),
    .count(cnt_dec), .carry_n(cy_dec), .borrow_n(bw_dec)
  );

  updown_dual_strobe_counter #(.WIDTH(W), .DECADE(1'b0)) i_updown_dual_strobe_counter_bin (
    .clk(clk), .rst(rst), .up_strobe(up_strobe), .down_strobe(down_strobe),
    .load_n(load_n), .clear(clear), .data_in(data_in),
    .count(cnt_bin), .carry_n(cy_bin), .borrow_n(bw_bin)
  );

  function automatic string req_name(input logic [3:0] id);
    case (id)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic [23:0] v);
    check(req, "decade count", cnt_dec, v[15:12]);
    check(req, "binary count", cnt_bin, v[11:8]);
    check(v[7] ? req : "R7", "decade carry_n", cy_dec, v[7]);
    check(v[6] ? req : "R7", "binary carry_n", cy_bin, v[6]);
    check(v[5] ? req : "R8", "decade borrow_n", bw_dec, v[5]);
    check(v[4] ? req : "R8", "binary borrow_n", bw_bin, v[4]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1", "reset decade count", cnt_dec, 0);
    check("R1", "reset binary count", cnt_bin, 0);
    check("R1", "reset carry_n", cy_dec, 1);
    check("R1", "reset borrow_n", bw_dec, 1);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1", "no count after reset", cnt_dec, 0);

    for (int i = 0; i < int'(NVEC); i++) begin
      clear       = VEC[i][23];
      load_n      = VEC[i][22];
      up_strobe   = VEC[i][21];
      down_strobe = VEC[i][20];
      data_in     = VEC[i][19:16];
      repeat (4) @(posedge clk);
      @(negedge clk);
      check_all(req_name(VEC[i][3:0]), VEC[i]);
    end

    // R9: latency of an up edge, count is 4 here
    up_strobe = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    up_strobe = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R9", "count after two edges", cnt_dec, 4);
    @(posedge clk);
    @(negedge clk);
    check("R9", "count after three edges", cnt_dec, 5);

    // R2: clear overrides a down edge arriving together with it
    down_strobe = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    down_strobe = 1'b1;
    clear = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R2", "clear beats down edge", cnt_bin, 0);
    clear = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R2", "count after clear released", cnt_dec, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule